// File: doc/BRIEF.md
# Multi-Ratio Bank Divider with Coincidence Pulse

This block takes one fast source clock and derives three divided clock waveforms and one marker pulse from it. Bank A and bank C each have their own divisor, and a 4-bit mode code picks the pair. The code space covers equal, integer (2:1, 3:1, 4:1) and non-integer (3:2, 4:3) frequency relations between the two banks. A feedback waveform has its own divisor, chosen by a separate 3-bit code, so a downstream phase comparator can run at a rate that does not depend on the banks.

When bank A and bank C have a non-integer relation, their rising edges line up only once every few periods. The coincidence pulse is high for one source cycle, in the cycle just before such a shared rising edge. Bank D is a steerable output: it carries either the coincidence pulse or a copy of bank C. In bypass mode the dividers do not advance on every source cycle. They advance only on cycles that carry a test-step strobe, so a design can be walked edge by edge. Several strobes may be needed for one output edge.

The mode and feedback codes are captured only while the master reset is active. The master reset also clears every divider together, so all outputs restart phase-aligned.

Top module: `mrdiv_top`

## Requirements
- R1: The bank divisors (A, C), in source ticks, are set by `mode_sel`: 0:(2,2) 1:(4,4) 2:(2,4) 3:(4,8) 4:(2,6) 5:(3,9) 6:(2,8) 7:(3,12) 8:(2,3) 9:(4,6) 10:(6,9) 11:(3,4) 12:(6,8) 13:(9,12) 14:(3,3) 15:(5,5).
- R2: A divider with divisor N has a period of N ticks. Its output is high for the first ceil(N/2) ticks of each period and low for the rest. Each period starts at tick 0 after reset release.
- R3: The feedback divisor is set by `fb_sel`: 0→2, 1→4, 2→6, 3→8, 4→12, 5→16. Codes 6 and 7 also select 16.
- R4: `sync_pulse` is high in exactly those running cycles that advance the dividers and are followed by a rising edge of both bank A and bank C. It is therefore never high in two consecutive cycles.
- R5: `bank_d` equals `sync_pulse` when `d_sync_sel` is 1, and equals `bank_c` when `d_sync_sel` is 0.
- R6: With `bypass` at 1, the dividers advance only in cycles where `test_step` is 1. In other cycles every divided output holds its value and `sync_pulse` is 0. With `bypass` at 0, the dividers advance every cycle.
- R7: `mode_sel` and `fb_sel` are captured only on clock edges while the internal reset is active. A change made while running has no effect until the next reset.
- R8: While reset is active, every divided output is 1 and `sync_pulse` is 0. After `rst_n` rises, the dividers hold for two clock edges and then all start counting from tick 0 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Master reset, active low, asynchronous assert |
| mode_sel | input | 4 | Bank divisor pair code |
| fb_sel | input | 3 | Feedback divisor code |
| d_sync_sel | input | 1 | Bank D source: 1 coincidence pulse, 0 bank C copy |
| bypass | input | 1 | Step mode: advance only on test_step |
| test_step | input | 1 | One-cycle advance strobe used in bypass mode |
| bank_a | output | 1 | Bank A divided waveform |
| bank_c | output | 1 | Bank C divided waveform |
| bank_d | output | 1 | Steered output (pulse or bank C copy) |
| fb_out | output | 1 | Feedback divided waveform |
| sync_pulse | output | 1 | Coincidence pulse before a shared A/C rising edge |

## Verification
The coincidence pulse and step-mode gating can act in the same cycle. A bank pair can reach its shared wrap point exactly when bypass mode withholds the step strobe, so the pulse has to wait for the cycle that actually advances. This case is provoked by running a non-integer mode in bypass with a pseudo-random strobe pattern. It is judged by a tick-counting model that expects the pulse only on an advancing cycle whose tick index sits on the last tick of both bank periods. A second overlap is a select-code change while running: it lands in the same cycles as ordinary counting, and the model keeps the codes captured at reset.

// File: rtl/mrdiv_pkg.sv
package mrdiv_pkg;
  localparam int DIV_W   = 5;
  localparam int MODE_W  = 4;
  localparam int FBSEL_W = 3;
  localparam int NUM_DIV = 3;

  typedef logic [DIV_W-1:0] div_t;

  typedef struct packed {
    div_t a;
    div_t c;
    div_t fb;
  } ratio_cfg_t;

  function automatic ratio_cfg_t decode_cfg(input logic [MODE_W-1:0]  mode,
                                            input logic [FBSEL_W-1:0] fsel);
    ratio_cfg_t r;
    case (mode)
      4'd0:    begin r.a = DIV_W'(2); r.c = DIV_W'(2);  end
      4'd1:    begin r.a = DIV_W'(4); r.c = DIV_W'(4);  end
      4'd2:    begin r.a = DIV_W'(2); r.c = DIV_W'(4);  end
      4'd3:    begin r.a = DIV_W'(4); r.c = DIV_W'(8);  end
      4'd4:    begin r.a = DIV_W'(2); r.c = DIV_W'(6);  end
      4'd5:    begin r.a = DIV_W'(3); r.c = DIV_W'(9);  end
      4'd6:    begin r.a = DIV_W'(2); r.c = DIV_W'(8);  end
      4'd7:    begin r.a = DIV_W'(3); r.c = DIV_W'(12); end
      4'd8:    begin r.a = DIV_W'(2); r.c = DIV_W'(3);  end
      4'd9:    begin r.a = DIV_W'(4); r.c = DIV_W'(6);  end
      4'd10:   begin r.a = DIV_W'(6); r.c = DIV_W'(9);  end
      4'd11:   begin r.a = DIV_W'(3); r.c = DIV_W'(4);  end
      4'd12:   begin r.a = DIV_W'(6); r.c = DIV_W'(8);  end
      4'd13:   begin r.a = DIV_W'(9); r.c = DIV_W'(12); end
      4'd14:   begin r.a = DIV_W'(3); r.c = DIV_W'(3);  end
      default: begin r.a = DIV_W'(5); r.c = DIV_W'(5);  end
    endcase
    case (fsel)
      3'd0:    r.fb = DIV_W'(2);
      3'd1:    r.fb = DIV_W'(4);
      3'd2:    r.fb = DIV_W'(6);
      3'd3:    r.fb = DIV_W'(8);
      3'd4:    r.fb = DIV_W'(12);
      default: r.fb = DIV_W'(16);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mrdiv_rstsync.sv
module mrdiv_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic run_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign run_n = sh_q[STAGES-1];
endmodule

// File: rtl/mrdiv_ctr.sv
module mrdiv_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] div,
  output logic         wave,
  output logic         last
);
  localparam int HW = W + 1;

  logic [W-1:0]  cnt_q;
  logic [W-1:0]  cnt_d;
  logic [HW-1:0] high_len;

  assign last     = (cnt_q == (div - 1'b1));
  assign high_len = ({1'b0, div} + 1'b1) >> 1;
  assign wave     = ({1'b0, cnt_q} < high_len);

  always_comb begin
    cnt_d = cnt_q;
    if (adv) begin
      if (last) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mrdiv_top.sv
module mrdiv_top
  import mrdiv_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  mode_sel,
  input  logic [FBSEL_W-1:0] fb_sel,
  input  logic               d_sync_sel,
  input  logic               bypass,
  input  logic               test_step,
  output logic               bank_a,
  output logic               bank_c,
  output logic               bank_d,
  output logic               fb_out,
  output logic               sync_pulse
);
  localparam int IDX_A  = 0;
  localparam int IDX_C  = 1;
  localparam int IDX_FB = 2;

  logic               run_n;
  logic               tick;
  ratio_cfg_t         cfg_q;
  ratio_cfg_t         cfg_d;
  div_t               div_sel [NUM_DIV];
  logic [NUM_DIV-1:0] wave;
  logic [NUM_DIV-1:0] last;

  mrdiv_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .run_n  (run_n)
  );

  // Codes load on every edge while held in reset, and are frozen while running.
  always_comb begin
    cfg_d = cfg_q;
    if (!run_n) cfg_d = decode_cfg(mode_sel, fb_sel);
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  assign tick = bypass ? test_step : 1'b1;

  assign div_sel[IDX_A]  = cfg_q.a;
  assign div_sel[IDX_C]  = cfg_q.c;
  assign div_sel[IDX_FB] = cfg_q.fb;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    mrdiv_ctr #(.W(DIV_W)) u_ctr (
      .clk   (clk),
      .rst_n (run_n),
      .adv   (tick),
      .div   (div_sel[g]),
      .wave  (wave[g]),
      .last  (last[g])
    );
  end

  assign bank_a     = wave[IDX_A];
  assign bank_c     = wave[IDX_C];
  assign fb_out     = wave[IDX_FB];
  assign sync_pulse = run_n & tick & last[IDX_A] & last[IDX_C];
  assign bank_d     = d_sync_sel ? sync_pulse : wave[IDX_C];
endmodule

// File: rtl/mrdiv_chk.sv
module mrdiv_chk
  import mrdiv_pkg::*;
(
  input logic       clk,
  input logic       run_n,
  input logic       bypass,
  input logic       test_step,
  input logic       bank_a,
  input logic       bank_c,
  input logic       fb_out,
  input logic       sync_pulse,
  input ratio_cfg_t cfg
);
  // R4
  sync_single_chk: assert property (@(posedge clk) disable iff (!run_n)
    sync_pulse |=> !sync_pulse);

  // R4
  sync_edge_chk: assert property (@(posedge clk) disable iff (!run_n)
    sync_pulse |=> ($rose(bank_a) && $rose(bank_c)));

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!run_n)
    (bypass && !test_step) |=> ($stable(bank_a) && $stable(bank_c) && $stable(fb_out)));

  // R6
  step_nosync_chk: assert property (@(posedge clk) disable iff (!run_n)
    (bypass && !test_step) |-> !sync_pulse);

  // R7
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!run_n)
    run_n |=> $stable(cfg));
endmodule

bind mrdiv_top mrdiv_chk u_chk (
  .clk        (clk),
  .run_n      (run_n),
  .bypass     (bypass),
  .test_step  (test_step),
  .bank_a     (bank_a),
  .bank_c     (bank_c),
  .fb_out     (fb_out),
  .sync_pulse (sync_pulse),
  .cfg        (cfg_q)
);

// File: tb/sim_mrdiv_top.sv
module sim_mrdiv_top;
  logic       clk;
  logic       rst_n;
  logic [3:0] mode_sel;
  logic [2:0] fb_sel;
  logic       d_sync_sel;
  logic       bypass;
  logic       test_step;
  logic       bank_a, bank_c, bank_d, fb_out, sync_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit started = 0;
  string phase = "R8";

  // model state
  int edges = 0;
  int t = 0;
  int cap_mode = 0;
  int cap_fb = 0;

  mrdiv_top u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fb_sel(fb_sel),
    .d_sync_sel(d_sync_sel), .bypass(bypass), .test_step(test_step),
    .bank_a(bank_a), .bank_c(bank_c), .bank_d(bank_d), .fb_out(fb_out),
    .sync_pulse(sync_pulse)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // R1 table
  function automatic int div_a(int m);
    int ta[16] = '{2,4,2,4,2,3,2,3,2,4,6,3,6,9,3,5};
    return ta[m];
  endfunction
  function automatic int div_c(int m);
    int tc[16] = '{2,4,4,8,6,9,8,12,3,6,9,4,8,12,3,5};
    return tc[m];
  endfunction
  // R3 table
  function automatic int div_f(int f);
    int tf[8] = '{2,4,6,8,12,16,16,16};
    return tf[f];
  endfunction

  function automatic bit wave_of(int tk, int n);
    return (tk % n) < ((n + 1) / 2);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [phase %s] %s actual=%0d expected=%0d at %0t",
               req, phase, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit tk;
    bit run;
    bit ea, ec, ef, es, ed;
    int ma, mc, mf;
    tk = !bypass || test_step;
    if (!rst_n) begin
      edges = 0; t = 0; cap_mode = int'(mode_sel); cap_fb = int'(fb_sel);
    end else if (edges < 2) begin
      edges++; t = 0; cap_mode = int'(mode_sel); cap_fb = int'(fb_sel);
    end else if (tk) begin
      t++;
    end
    #2;
    if (started && !done) begin
      tk  = !bypass || test_step;
      run = rst_n && (edges >= 2);
      ma = div_a(cap_mode); mc = div_c(cap_mode); mf = div_f(cap_fb);
      ea = wave_of(t, ma);
      ec = wave_of(t, mc);
      ef = wave_of(t, mf);
      es = run && tk && ((t % ma) == ma - 1) && ((t % mc) == mc - 1);
      ed = d_sync_sel ? es : ec;
      chk(bank_a === ea, "R1", "bank_a", int'(bank_a), int'(ea));
      chk(bank_c === ec, "R2", "bank_c", int'(bank_c), int'(ec));
      chk(fb_out === ef, "R3", "fb_out", int'(fb_out), int'(ef));
      chk(sync_pulse === es, "R4", "sync_pulse", int'(sync_pulse), int'(es));
      chk(bank_d === ed, "R5", "bank_d", int'(bank_d), int'(ed));
    end
  end

  task automatic do_reset(int m, int f);
    @(negedge clk);
    rst_n = 0; mode_sel = 4'(m); fb_sel = 3'(f);
    repeat (3) @(negedge clk);
    // R8: held state during reset
    chk(bank_a && bank_c && fb_out && !sync_pulse, "R8", "reset outputs",
        int'({bank_a, bank_c, fb_out, sync_pulse}), 4'b1110);
    rst_n = 1;
  endtask

  initial begin
    int lfsr;
    rst_n = 0; mode_sel = 4'd8; fb_sel = 3'd0;
    d_sync_sel = 0; bypass = 0; test_step = 0;
    repeat (2) @(negedge clk);
    started = 1;

    phase = "R1";
    do_reset(8, 0);
    repeat (60) @(negedge clk);

    phase = "R4";
    d_sync_sel = 1;
    do_reset(11, 1);
    repeat (60) @(negedge clk);

    phase = "R2";
    for (int m = 0; m < 16; m++) begin
      d_sync_sel = m[0];
      do_reset(m, m % 8);
      repeat (45) @(negedge clk);
    end

    phase = "R3";
    d_sync_sel = 0;
    do_reset(13, 6);
    repeat (80) @(negedge clk);

    phase = "R6";
    d_sync_sel = 1;
    do_reset(12, 4);
    bypass = 1;
    lfsr = 32'h5a;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      test_step = lfsr[0] & lfsr[3];
    end
    @(negedge clk);
    test_step = 0;
    do_reset(10, 2);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      test_step = (i % 3 == 1);
    end
    @(negedge clk);
    bypass = 0; test_step = 0;

    phase = "R7";
    d_sync_sel = 0;
    do_reset(9, 3);
    repeat (20) @(negedge clk);
    mode_sel = 4'd2; fb_sel = 3'd0;
    repeat (60) @(negedge clk);
    do_reset(2, 0);
    repeat (30) @(negedge clk);

    phase = "R8";
    rst_n = 0;
    @(negedge clk);
    chk(bank_a && bank_c && fb_out && !sync_pulse, "R8", "async reset outputs",
        int'({bank_a, bank_c, fb_out, sync_pulse}), 4'b1110);
    rst_n = 1;
    repeat (40) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog [phase %s] actual=%0d expected=%0d", phase, 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule